// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the hardwired control unit of a small multicycle processor core. A one-hot step register walks through five steps (T1 fetch, T2 decode and register read, T3 execute, T4 memory, T5 write-back) and then returns to T1. Combinational decode turns the current step, the 4-bit opcode, the 3-bit function code and the memory-complete handshake into every datapath control line. These lines are the address, operand, result and destination mux selects, the register file write, the memory read and write strobes, the 3-bit ALU control, the immediate extension mode and the IR and PC load enables.

The supported operations are register-to-register add, subtract, AND and OR, plus word load and word store. Any step that talks to memory raises a wait-for-memory flag. While that flag is high the step register holds until memory signals completion. Its enable is the complement of the wait flag ORed with the completion input. The datapath, the register file and the memory are outside the block.

Top module: `mcs_ctrl_top`

## Requirements
- R1: While rst_ni is low and on the first cycle after it rises, step_o is 5'b00001 (T1, bit i = step T(i+1)), and rf_we_o and mem_wr_o are 0.
- R2: When no wait is pending, step_o moves one position per clock, T1 to T2 to T3 to T4 to T5, and from T5 it returns to T1.
- R3: wmfc_o is 1 in T1 and in T4 of a load (opcode 0100) or store (opcode 0101), and 0 otherwise. While wmfc_o is 1 and mfc_i is 0, step_o holds its value.
- R4: In T1, ma_sel_o=1, mem_rd_o=1, pc_sel_o=1 and inc_sel_o=0, while pc_en_o and ir_en_o both equal mfc_i.
- R5: In T3 of an R-type instruction (opcode 0000), b_sel_o=0 and alu_ctl_o follows func_i: add 011 gives 010, subtract 000 gives 110, AND 101 gives 000, OR 100 gives 001, and any other code gives 010.
- R6: In T3 of a load or store, b_sel_o=1, ext_mode_o=00 (sign-extend the 7-bit field) and alu_ctl_o=010.
- R7: An R-type instruction drives y_sel_o=00 in T4. In T5 it asserts rf_we_o with c_sel_o=01.
- R8: A load drives ma_sel_o=0, mem_rd_o=1 and y_sel_o=01 in T4. In T5 it asserts rf_we_o with c_sel_o=00.
- R9: A store asserts mem_wr_o only in T4. Its T5 asserts no strobe.
- R10: Any other opcode walks through all five steps, and after T1 it never asserts rf_we_o, mem_rd_o or mem_wr_o.
- R11: Every control output not called for in the current step and opcode is 0, including all outputs in T2.
- R12: mem_rd_o and mem_wr_o are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 4 | Opcode field from the instruction register |
| func_i | input | 3 | R-type function field from the instruction register |
| mfc_i | input | 1 | Memory function complete |
| step_o | output | 5 | One-hot current step, bit 0 = T1 |
| wmfc_o | output | 1 | Waiting for memory completion in this step |
| ma_sel_o | output | 1 | Memory address source: 1 = PC, 0 = RZ |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| inc_sel_o | output | 1 | PC adder increment select |
| pc_sel_o | output | 1 | PC input mux select |
| pc_en_o | output | 1 | PC load enable |
| ir_en_o | output | 1 | Instruction register load enable |
| b_sel_o | output | 1 | ALU B operand: 0 = RB, 1 = immediate |
| y_sel_o | output | 2 | RY source: 00 = RZ, 01 = memory data |
| c_sel_o | output | 2 | Destination register field select |
| rf_we_o | output | 1 | Register file write enable |
| alu_ctl_o | output | 3 | ALU control {F,G1,G0} |
| ext_mode_o | output | 2 | Immediate extension mode |

## Verification
The hardest situation to reach from the ports is a long memory stall inside T4 of a load or store. The control outputs must stay frozen there while mfc_i toggles in the surrounding steps where it has no effect. The stimulus chooses a wait length before each instruction, for both T1 and T4. It holds mfc_i low for exactly that many cycles and drives mfc_i randomly in steps that do not wait. A cycle-level reference model in the bench, which tracks its own step, is compared against every output on every cycle. This covers directed opcode and function-code corners, unknown opcodes and a reset in the middle of an instruction.

// File: rtl/mcs_pkg.sv
`timescale 1ns/1ps
package mcs_pkg;
  localparam int OP_W    = 4;
  localparam int FN_W    = 3;
  localparam int STEPS   = 5;
  localparam int ALU_W   = 3;
  localparam int SEL_W   = 2;

  // step indices into the one-hot vector
  localparam int S_FETCH = 0;
  localparam int S_DEC   = 1;
  localparam int S_EXE   = 2;
  localparam int S_MEM   = 3;
  localparam int S_WB    = 4;

  localparam logic [OP_W-1:0] OPC_RTYPE = 4'b0000;
  localparam logic [OP_W-1:0] OPC_LOAD  = 4'b0100;
  localparam logic [OP_W-1:0] OPC_STORE = 4'b0101;

  localparam logic [FN_W-1:0] FN_ADD = 3'b011;
  localparam logic [FN_W-1:0] FN_SUB = 3'b000;
  localparam logic [FN_W-1:0] FN_AND = 3'b101;
  localparam logic [FN_W-1:0] FN_OR  = 3'b100;

  localparam logic [ALU_W-1:0] ALU_ADD = 3'b010;
  localparam logic [ALU_W-1:0] ALU_SUB = 3'b110;
  localparam logic [ALU_W-1:0] ALU_AND = 3'b000;
  localparam logic [ALU_W-1:0] ALU_OR  = 3'b001;

  typedef enum logic [1:0] {
    EXT_S7  = 2'b00,
    EXT_Z7  = 2'b01,
    EXT_S16 = 2'b10,
    EXT_Z20 = 2'b11
  } ext_mode_e;

  localparam logic [SEL_W-1:0] Y_FROM_RZ  = 2'b00;
  localparam logic [SEL_W-1:0] Y_FROM_MEM = 2'b01;
  localparam logic [SEL_W-1:0] C_RT_FIELD = 2'b00;
  localparam logic [SEL_W-1:0] C_RD_FIELD = 2'b01;

  typedef struct packed {
    logic              ma_sel;
    logic              mem_rd;
    logic              mem_wr;
    logic              inc_sel;
    logic              pc_sel;
    logic              pc_en;
    logic              ir_en;
    logic              b_sel;
    logic [SEL_W-1:0]  y_sel;
    logic [SEL_W-1:0]  c_sel;
    logic              rf_we;
    logic [ALU_W-1:0]  alu_ctl;
    ext_mode_e         ext_mode;
    logic              wmfc;
  } ctrl_t;
endpackage

// File: rtl/mcs_step_ctr.sv
`timescale 1ns/1ps
module mcs_step_ctr #(
  parameter int N = mcs_pkg::STEPS
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  output logic [N-1:0] step_o
);
  logic [N-1:0] step_q;
  logic [N-1:0] step_rot;

  // rotate left: last step wraps to the first
  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_rot
      if (gi == 0) begin : g_wrap
        assign step_rot[gi] = step_q[N-1];
      end else begin : g_shift
        assign step_rot[gi] = step_q[gi-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    step_q <= N'(1);
    else if (adv_i) step_q <= step_rot;
  end

  assign step_o = step_q;
endmodule

// File: rtl/mcs_alu_ctl.sv
`timescale 1ns/1ps
module mcs_alu_ctl
  import mcs_pkg::*;
(
  input  logic             rtype_i,
  input  logic [FN_W-1:0]  func_i,
  output logic [ALU_W-1:0] alu_o
);
  always_comb begin
    alu_o = ALU_ADD;  // memory ops and unknown function codes add
    if (rtype_i) begin
      unique case (func_i)
        FN_SUB:  alu_o = ALU_SUB;
        FN_AND:  alu_o = ALU_AND;
        FN_OR:   alu_o = ALU_OR;
        default: alu_o = ALU_ADD;
      endcase
    end
  end
endmodule

// File: rtl/mcs_decode.sv
`timescale 1ns/1ps
module mcs_decode
  import mcs_pkg::*;
(
  input  logic [STEPS-1:0] step_i,
  input  logic [OP_W-1:0]  opcode_i,
  input  logic [ALU_W-1:0] alu_i,
  input  logic             mfc_i,
  output ctrl_t            ctrl_o
);
  logic is_r, is_ld, is_st, is_mem;

  assign is_r   = (opcode_i == OPC_RTYPE);
  assign is_ld  = (opcode_i == OPC_LOAD);
  assign is_st  = (opcode_i == OPC_STORE);
  assign is_mem = is_ld | is_st;

  always_comb begin
    ctrl_o = '0;
    if (step_i[S_FETCH]) begin
      ctrl_o.ma_sel  = 1'b1;
      ctrl_o.mem_rd  = 1'b1;
      ctrl_o.inc_sel = 1'b0;
      ctrl_o.pc_sel  = 1'b1;
      ctrl_o.pc_en   = mfc_i;  // advance PC once, on completion
      ctrl_o.ir_en   = mfc_i;
      ctrl_o.wmfc    = 1'b1;
    end
    if (step_i[S_EXE]) begin
      if (is_r) begin
        ctrl_o.b_sel   = 1'b0;
        ctrl_o.alu_ctl = alu_i;
      end else if (is_mem) begin
        ctrl_o.b_sel    = 1'b1;
        ctrl_o.ext_mode = EXT_S7;
        ctrl_o.alu_ctl  = alu_i;
      end
    end
    if (step_i[S_MEM]) begin
      if (is_r) begin
        ctrl_o.y_sel = Y_FROM_RZ;
      end else if (is_ld) begin
        ctrl_o.ma_sel = 1'b0;
        ctrl_o.mem_rd = 1'b1;
        ctrl_o.y_sel  = Y_FROM_MEM;
        ctrl_o.wmfc   = 1'b1;
      end else if (is_st) begin
        ctrl_o.ma_sel = 1'b0;
        ctrl_o.mem_wr = 1'b1;
        ctrl_o.wmfc   = 1'b1;
      end
    end
    if (step_i[S_WB]) begin
      if (is_r) begin
        ctrl_o.rf_we = 1'b1;
        ctrl_o.c_sel = C_RD_FIELD;
      end else if (is_ld) begin
        ctrl_o.rf_we = 1'b1;
        ctrl_o.c_sel = C_RT_FIELD;
      end
    end
  end
endmodule

// File: rtl/mcs_ctrl_top.sv
`timescale 1ns/1ps
module mcs_ctrl_top
  import mcs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OP_W-1:0]  opcode_i,
  input  logic [FN_W-1:0]  func_i,
  input  logic             mfc_i,
  output logic [STEPS-1:0] step_o,
  output logic             wmfc_o,
  output logic             ma_sel_o,
  output logic             mem_rd_o,
  output logic             mem_wr_o,
  output logic             inc_sel_o,
  output logic             pc_sel_o,
  output logic             pc_en_o,
  output logic             ir_en_o,
  output logic             b_sel_o,
  output logic [SEL_W-1:0] y_sel_o,
  output logic [SEL_W-1:0] c_sel_o,
  output logic             rf_we_o,
  output logic [ALU_W-1:0] alu_ctl_o,
  output logic [1:0]       ext_mode_o
);
  logic [STEPS-1:0] step;
  logic [ALU_W-1:0] alu_code;
  logic             adv;
  ctrl_t            ctrl;

  mcs_step_ctr #(.N(STEPS)) u_step (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv),
    .step_o (step)
  );

  mcs_alu_ctl u_alu (
    .rtype_i (opcode_i == OPC_RTYPE),
    .func_i  (func_i),
    .alu_o   (alu_code)
  );

  mcs_decode u_dec (
    .step_i   (step),
    .opcode_i (opcode_i),
    .alu_i    (alu_code),
    .mfc_i    (mfc_i),
    .ctrl_o   (ctrl)
  );

  // hold the step while a memory access is outstanding
  assign adv = ~ctrl.wmfc | mfc_i;

  assign step_o     = step;
  assign wmfc_o     = ctrl.wmfc;
  assign ma_sel_o   = ctrl.ma_sel;
  assign mem_rd_o   = ctrl.mem_rd;
  assign mem_wr_o   = ctrl.mem_wr;
  assign inc_sel_o  = ctrl.inc_sel;
  assign pc_sel_o   = ctrl.pc_sel;
  assign pc_en_o    = ctrl.pc_en;
  assign ir_en_o    = ctrl.ir_en;
  assign b_sel_o    = ctrl.b_sel;
  assign y_sel_o    = ctrl.y_sel;
  assign c_sel_o    = ctrl.c_sel;
  assign rf_we_o    = ctrl.rf_we;
  assign alu_ctl_o  = ctrl.alu_ctl;
  assign ext_mode_o = ctrl.ext_mode;
endmodule

// File: rtl/mcs_ctrl_chk.sv
`timescale 1ns/1ps
module mcs_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mfc_i,
  input logic [4:0] step_o,
  input logic       wmfc_o,
  input logic       mem_rd_o,
  input logic       mem_wr_o,
  input logic       ir_en_o,
  input logic       rf_we_o
);
  // R2
  step_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(step_o) == 1);
  // R2
  step_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o[4] |=> step_o[0]);
  // R3
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wmfc_o && !mfc_i) |=> $stable(step_o));
  // R4
  ir_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_en_o |-> (step_o[0] && mfc_i));
  // R9
  wr_in_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> (step_o[3] && wmfc_o));
  // R7
  rf_we_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> step_o[4]);
  // R12
  rd_wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));
endmodule

bind mcs_ctrl_top mcs_ctrl_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mfc_i    (mfc_i),
  .step_o   (step_o),
  .wmfc_o   (wmfc_o),
  .mem_rd_o (mem_rd_o),
  .mem_wr_o (mem_wr_o),
  .ir_en_o  (ir_en_o),
  .rf_we_o  (rf_we_o)
);

// File: tb/tb_mcs_ctrl_top.sv
`timescale 1ns/1ps
module tb_mcs_ctrl_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] opcode = 4'h0;
  logic [2:0] func = 3'h0;
  logic       mfc = 1'b0;

  logic [4:0] step;
  logic       wmfc, ma_sel, mem_rd, mem_wr, inc_sel, pc_sel, pc_en, ir_en, b_sel, rf_we;
  logic [1:0] y_sel, c_sel, ext_mode;
  logic [2:0] alu_ctl;

  int checks = 0;
  int fails  = 0;
  int s      = 0;  // bench step index, 0 = T1

  always #4 clk = ~clk;

  mcs_ctrl_top dut (
    .clk_i(clk), .rst_ni(rst_n), .opcode_i(opcode), .func_i(func), .mfc_i(mfc),
    .step_o(step), .wmfc_o(wmfc), .ma_sel_o(ma_sel), .mem_rd_o(mem_rd),
    .mem_wr_o(mem_wr), .inc_sel_o(inc_sel), .pc_sel_o(pc_sel), .pc_en_o(pc_en),
    .ir_en_o(ir_en), .b_sel_o(b_sel), .y_sel_o(y_sel), .c_sel_o(c_sel),
    .rf_we_o(rf_we), .alu_ctl_o(alu_ctl), .ext_mode_o(ext_mode)
  );

  wire [18:0] act = {ma_sel, mem_rd, mem_wr, inc_sel, pc_sel, pc_en, ir_en, b_sel,
                     y_sel, c_sel, rf_we, alu_ctl, ext_mode, wmfc};

  function automatic logic is_mem_op(input logic [3:0] op);
    return (op == 4'b0100) || (op == 4'b0101);
  endfunction

  function automatic logic model_wait(input int st, input logic [3:0] op);
    return (st == 0) || (st == 3 && is_mem_op(op));
  endfunction

  function automatic logic [2:0] model_alu(input logic [3:0] op, input logic [2:0] fn);
    if (op != 4'b0000) return 3'b010;
    case (fn)
      3'b000:  return 3'b110;
      3'b101:  return 3'b000;
      3'b100:  return 3'b001;
      default: return 3'b010;
    endcase
  endfunction

  function automatic logic [18:0] model(input int st, input logic [3:0] op,
                                        input logic [2:0] fn, input logic m);
    logic ma, rd, wr, inc, ps, pe, ie, bs, we, wm;
    logic [1:0] ys, cs, ex;
    logic [2:0] al;
    {ma, rd, wr, inc, ps, pe, ie, bs, we, wm} = '0;
    ys = 2'b00; cs = 2'b00; ex = 2'b00; al = 3'b000;
    case (st)
      0: begin ma = 1; rd = 1; ps = 1; pe = m; ie = m; wm = 1; end
      2: if (op == 4'b0000) begin al = model_alu(op, fn); end
         else if (is_mem_op(op)) begin bs = 1; al = 3'b010; end
      3: if (op == 4'b0100) begin rd = 1; ys = 2'b01; wm = 1; end
         else if (op == 4'b0101) begin wr = 1; wm = 1; end
      4: if (op == 4'b0000) begin we = 1; cs = 2'b01; end
         else if (op == 4'b0100) begin we = 1; end
      default: ;
    endcase
    return {ma, rd, wr, inc, ps, pe, ie, bs, ys, cs, we, al, ex, wm};
  endfunction

  function automatic string req_tag(input int st, input logic [3:0] op);
    if (st == 0) return "R4";
    if (st == 1) return "R11";
    if (op != 4'b0000 && !is_mem_op(op)) return "R10";
    if (st == 2) return (op == 4'b0000) ? "R5" : "R6";
    if (op == 4'b0000) return "R7";
    return (op == 4'b0100) ? "R8" : "R9";
  endfunction

  task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s step=T%0d op=%b fn=%b actual=%h expected=%h",
               tag, s + 1, opcode, func, a, e);
    end
  endtask

  // one clock: drive, check outputs mid-cycle, advance the bench step
  task automatic cyc(input logic m);
    logic en;
    @(negedge clk);
    mfc = m;
    #1;
    chk(model_wait(s, opcode) ? "R3" : "R2", {27'd0, step}, 32'(1 << s));
    chk(req_tag(s, opcode), {13'd0, act}, {13'd0, model(s, opcode, func, m)});
    // R12
    chk("R12", {31'd0, mem_rd & mem_wr}, 32'd0);
    en = !model_wait(s, opcode) || m;
    @(posedge clk);
    if (en) s = (s == 4) ? 0 : s + 1;
  endtask

  task automatic instr(input logic [3:0] op, input logic [2:0] fn,
                       input int w1, input int w4);
    for (int i = 0; i < w1; i++) cyc(1'b0);
    opcode = op;  // IR holds the new word from the end of T1
    func   = fn;
    cyc(1'b1);
    for (int st = 1; st < 5; st++) begin
      if (st == 3 && is_mem_op(op)) begin
        for (int i = 0; i < w4; i++) cyc(1'b0);
        cyc(1'b1);
      end else begin
        cyc(1'($urandom_range(0, 1)));
      end
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    // R1: reset state, both during and right after reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", {27'd0, step}, 32'h1);
    chk("R1", {30'd0, rf_we, mem_wr}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1", {27'd0, step}, 32'h1);
    chk("R1", {30'd0, rf_we, mem_wr}, 32'd0);

    // R5: each R-type function plus an unknown code
    instr(4'b0000, 3'b011, 0, 0);
    instr(4'b0000, 3'b000, 1, 0);
    instr(4'b0000, 3'b101, 0, 0);
    instr(4'b0000, 3'b100, 2, 0);
    instr(4'b0000, 3'b110, 0, 0);
    // R6, R8, R9: memory ops with long stalls in T4
    instr(4'b0100, 3'b111, 0, 6);
    instr(4'b0101, 3'b010, 3, 5);
    instr(4'b0100, 3'b000, 0, 0);
    instr(4'b0101, 3'b000, 0, 0);
    // R10: unknown opcodes
    instr(4'b1111, 3'b011, 0, 0);
    instr(4'b0110, 3'b000, 1, 0);

    // R1: reset in the middle of a load stalled in T4
    opcode = 4'b0100;
    cyc(1'b1); cyc(1'b0); cyc(1'b0); cyc(1'b0); cyc(1'b0);
    @(negedge clk);
    mfc = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R1", {27'd0, step}, 32'h1);
    @(negedge clk);
    rst_n = 1'b1;
    s = 0;

    for (int n = 0; n < 400; n++) begin
      logic [3:0] op;
      int sel = $urandom_range(0, 3);
      op = (sel == 0) ? 4'b0000 : (sel == 1) ? 4'b0100 :
           (sel == 2) ? 4'b0101 : 4'($urandom_range(0, 15));
      instr(op, 3'($urandom_range(0, 7)), $urandom_range(0, 3), $urandom_range(0, 4));
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule